// File: doc/BRIEF.md
# Subword Atomic Memory Operation Unit

This unit carries out one atomic read-modify-write at a time on a 64-bit memory port. It handles the byte and halfword widths as well as the word and doubleword widths. A request carries an operation, a width code, a byte address, a source operand and, for compare-and-swap, an expected value.

The unit reads the containing 64-bit word and isolates the addressed lane. It applies the operation to that lane alone and writes back only the bytes of the lane. It then returns the old lane value, sign-extended to 64 bits, for the destination register. Misaligned and illegal requests are answered without touching memory.

A single-byte access watchpoint is matched against exactly the bytes the access covers. The acquire and release flags are not interpreted. They are carried from the request to the response.

Top module: `subword_amo_unit`

## Requirements
- R1: The width code selects the lane size: 000 is byte, 001 is halfword, 010 is word and 011 is doubleword. Codes 100 to 111 are answered with the illegal flag set, rd not written, and no memory read or write.
- R2: The operation code gives the computation on the lane. 0 is swap, 1 is add (wrapping at lane width), 2 is xor, 3 is and, 4 is or, 5 is signed min, 6 is signed max, 7 is unsigned min, 8 is unsigned max and 9 is compare-and-swap.
- R3: rsp_rd holds the old lane value sign-extended from the lane width, and rsp_rd_we is 1. This holds for every operation, the unsigned min and max included; for example a byte 0x80 returns 0xFFFF_FFFF_FFFF_FF80.
- R4: Only the low lane-width bits of req_rs2 take part in the result. The upper bits have no effect on memory or on rsp_rd.
- R5: Compare-and-swap compares the old lane with the low lane-width bits of req_cmp. On a match the lane is written with req_rs2. On a mismatch no write is issued. Either way the old lane is returned sign-extended.
- R6: The lane starts at byte offset addr[2:0]. The single write of an operation asserts mem_wstrb only for the lane bytes, so every other byte of memory is left unchanged.
- R7: Signed min and max compare the lanes as two's-complement numbers of the lane width. Unsigned min and max compare them as unsigned numbers of the lane width.
- R8: An address not aligned to the lane size (halfword addr[0]=1, word addr[1:0]≠0, doubleword addr[2:0]≠0) sets rsp_misaligned. It issues no memory read or write and leaves rsp_rd_we at 0.
- R9: Operation codes 10 (load-reserved) and 11 (store-conditional), and all codes above 11, are answered with the illegal flag set, rsp_rd_we at 0 and no memory access. This applies at every width, byte and halfword included.
- R10: rsp_wp_hit is 1 only when wp_en is set and the byte address wp_addr lies within the bytes of the completed access. A faulting or illegal request never hits.
- R11: The memory port is used one direction at a time: a read, then at most one write. rsp_aq and rsp_rl return the request's req_aq and req_rl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted when valid |
| req_op | input | 4 | Operation code |
| req_width | input | 3 | Width code |
| req_addr | input | ADDR_W | Byte address |
| req_rs2 | input | XLEN | Source operand |
| req_cmp | input | XLEN | Expected value for compare-and-swap |
| req_aq | input | 1 | Acquire flag |
| req_rl | input | 1 | Release flag |
| wp_en | input | 1 | Watchpoint enable |
| wp_addr | input | ADDR_W | Watched byte address |
| mem_rd_valid | output | 1 | Read request, held until done |
| mem_wr_valid | output | 1 | Write request, held until done |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | XLEN | Write data, lane in place |
| mem_wstrb | output | XLEN/8 | Byte strobes |
| mem_rd_done | input | 1 | Read data valid |
| mem_rdata | input | XLEN | Read data |
| mem_wr_done | input | 1 | Write completed |
| rsp_valid | output | 1 | Response, one cycle |
| rsp_rd | output | XLEN | Sign-extended old lane |
| rsp_rd_we | output | 1 | Destination write enable |
| rsp_misaligned | output | 1 | Misaligned-access fault |
| rsp_illegal | output | 1 | Illegal encoding |
| rsp_wp_hit | output | 1 | Watchpoint matched |
| rsp_aq | output | 1 | Echoed acquire flag |
| rsp_rl | output | 1 | Echoed release flag |

## Verification
Two functions can meet in one response: the watchpoint match and the alignment fault. A halfword request whose odd address is the watched byte sets up that meeting. The response must then show the fault with no hit, and memory must stay untouched. The second meeting is between the lane merge and the compare-and-swap decision. Each compare is tried twice on the same byte, once matching and once not. Memory is checked after each response so that a suppressed write, or a stray strobe on a neighbouring byte, shows up.

// File: rtl/subword_amo_unit.sv
module subword_amo_unit #(
  parameter int ADDR_W = 32,
  parameter int XLEN   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [2:0]        req_width,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [XLEN-1:0]   req_rs2,
  input  logic [XLEN-1:0]   req_cmp,
  input  logic              req_aq,
  input  logic              req_rl,
  input  logic              wp_en,
  input  logic [ADDR_W-1:0] wp_addr,
  output logic              mem_rd_valid,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [XLEN/8-1:0] mem_wstrb,
  input  logic              mem_rd_done,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic              mem_wr_done,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_rd,
  output logic              rsp_rd_we,
  output logic              rsp_misaligned,
  output logic              rsp_illegal,
  output logic              rsp_wp_hit,
  output logic              rsp_aq,
  output logic              rsp_rl
);
  localparam int NB    = XLEN / 8;
  localparam int OFF_W = $clog2(NB);

  localparam logic [3:0] OP_SWAP = 4'd0, OP_ADD = 4'd1, OP_XOR = 4'd2, OP_AND = 4'd3,
                         OP_OR = 4'd4, OP_MIN = 4'd5, OP_MAX = 4'd6, OP_MINU = 4'd7,
                         OP_MAXU = 4'd8, OP_CAS = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_RESP} state_t;

  function automatic logic [XLEN-1:0] sext(input logic [XLEN-1:0] v, input logic [2:0] w);
    case (w)
      3'd0:    return {{(XLEN-8){v[7]}}, v[7:0]};
      3'd1:    return {{(XLEN-16){v[15]}}, v[15:0]};
      3'd2:    return {{(XLEN-32){v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] zext(input logic [XLEN-1:0] v, input logic [2:0] w);
    case (w)
      3'd0:    return {{(XLEN-8){1'b0}}, v[7:0]};
      3'd1:    return {{(XLEN-16){1'b0}}, v[15:0]};
      3'd2:    return {{(XLEN-32){1'b0}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  state_t            st;
  logic [3:0]        op_q;
  logic [2:0]        wd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [XLEN-1:0]   rs2_q, cmp_q, old_q;
  logic              aq_q, rl_q, mis_q, ill_q;

  // request decode
  logic req_ill, req_mis;
  assign req_ill = (req_width > 3'd3) || (req_op > OP_CAS);
  always_comb begin
    case (req_width)
      3'd1:    req_mis = req_addr[0];
      3'd2:    req_mis = |req_addr[1:0];
      3'd3:    req_mis = |req_addr[OFF_W-1:0];
      default: req_mis = 1'b0;
    endcase
    if (req_ill) req_mis = 1'b0;
  end

  // lane geometry
  logic [NB-1:0]      lane_bytes, acc_mask;
  logic [OFF_W-1:0]   off;
  logic [OFF_W+2:0]   sh;
  always_comb begin
    case (wd_q)
      3'd0:    lane_bytes = NB'(8'h01);
      3'd1:    lane_bytes = NB'(8'h03);
      3'd2:    lane_bytes = NB'(8'h0F);
      default: lane_bytes = '1;
    endcase
  end
  assign off      = addr_q[OFF_W-1:0];
  assign sh       = {off, 3'b000};
  assign acc_mask = lane_bytes << off;

  // lane ALU
  logic [XLEN-1:0] lane_raw, old_u, old_s, b_u, b_s, c_u, res;
  logic            lt_s, lt_u, cas_hit, skip_wr;
  assign lane_raw = old_q >> sh;
  assign old_u    = zext(lane_raw, wd_q);
  assign old_s    = sext(lane_raw, wd_q);
  assign b_u      = zext(rs2_q, wd_q);
  assign b_s      = sext(rs2_q, wd_q);
  assign c_u      = zext(cmp_q, wd_q);
  assign lt_s     = $signed(old_s) < $signed(b_s);
  assign lt_u     = old_u < b_u;
  assign cas_hit  = old_u == c_u;
  assign skip_wr  = (op_q == OP_CAS) && !cas_hit;

  always_comb begin
    case (op_q)
      OP_ADD:  res = old_u + b_u;
      OP_XOR:  res = old_u ^ b_u;
      OP_AND:  res = old_u & b_u;
      OP_OR:   res = old_u | b_u;
      OP_MIN:  res = lt_s ? old_u : b_u;
      OP_MAX:  res = lt_s ? b_u : old_u;
      OP_MINU: res = lt_u ? old_u : b_u;
      OP_MAXU: res = lt_u ? b_u : old_u;
      default: res = b_u;
    endcase
  end

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      wd_q   <= '0;
      addr_q <= '0;
      rs2_q  <= '0;
      cmp_q  <= '0;
      old_q  <= '0;
      aq_q   <= 1'b0;
      rl_q   <= 1'b0;
      mis_q  <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          wd_q   <= req_width;
          addr_q <= req_addr;
          rs2_q  <= req_rs2;
          cmp_q  <= req_cmp;
          aq_q   <= req_aq;
          rl_q   <= req_rl;
          ill_q  <= req_ill;
          mis_q  <= req_mis;
          old_q  <= '0;
          st     <= (req_ill || req_mis) ? S_RESP : S_READ;
        end
        S_READ: if (mem_rd_done) begin
          old_q <= mem_rdata;
          st    <= S_WRITE;
        end
        S_WRITE: if (skip_wr || mem_wr_done) st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic ok;
  assign ok             = !ill_q && !mis_q;
  assign req_ready      = (st == S_IDLE);
  assign mem_rd_valid   = (st == S_READ);
  assign mem_wr_valid   = (st == S_WRITE) && !skip_wr;
  assign mem_addr       = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata      = res << sh;
  assign mem_wstrb      = mem_wr_valid ? acc_mask : '0;
  assign rsp_valid      = (st == S_RESP);
  assign rsp_rd         = ok ? old_s : '0;
  assign rsp_rd_we      = rsp_valid && ok;
  assign rsp_misaligned = rsp_valid && mis_q;
  assign rsp_illegal    = rsp_valid && ill_q;
  assign rsp_wp_hit     = rsp_valid && ok && wp_en &&
                          (wp_addr[ADDR_W-1:OFF_W] == addr_q[ADDR_W-1:OFF_W]) &&
                          acc_mask[wp_addr[OFF_W-1:0]];
  assign rsp_aq         = aq_q;
  assign rsp_rl         = rl_q;

  // checks
  assert_one_direction_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_valid && mem_wr_valid));
  assert_write_follows_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_valid) |-> $past(mem_rd_valid && mem_rd_done));
  assert_byte_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && wd_q == 3'd0) |-> $countones(mem_wstrb) == 1);
  assert_half_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && wd_q == 3'd1) |-> $countones(mem_wstrb) == 2);
  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st != S_IDLE) && (mis_q || ill_q)) |-> !(mem_rd_valid || mem_wr_valid));
  assert_fault_no_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_misaligned || rsp_illegal) |-> !rsp_rd_we);
  assert_fault_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_misaligned || rsp_illegal) |-> !rsp_wp_hit);
endmodule

// File: tb/test_subword_amo_unit.sv
module test_subword_amo_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [3:0]  req_op = '0;
  logic [2:0]  req_width = '0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_rs2 = '0, req_cmp = '0;
  logic        req_aq = 1'b0, req_rl = 1'b0;
  logic        wp_en = 1'b0;
  logic [31:0] wp_addr = '0;
  logic        mem_rd_valid, mem_wr_valid;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_wstrb;
  logic        mem_rd_done, mem_wr_done;
  logic [63:0] mem_rdata;
  logic        rsp_valid, rsp_rd_we, rsp_misaligned, rsp_illegal, rsp_wp_hit, rsp_aq, rsp_rl;
  logic [63:0] rsp_rd;

  always #5 clk = ~clk;

  subword_amo_unit i_subword_amo_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_width(req_width), .req_addr(req_addr), .req_rs2(req_rs2),
    .req_cmp(req_cmp), .req_aq(req_aq), .req_rl(req_rl), .wp_en(wp_en), .wp_addr(wp_addr),
    .mem_rd_valid(mem_rd_valid), .mem_wr_valid(mem_wr_valid), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rd_done(mem_rd_done),
    .mem_rdata(mem_rdata), .mem_wr_done(mem_wr_done), .rsp_valid(rsp_valid),
    .rsp_rd(rsp_rd), .rsp_rd_we(rsp_rd_we), .rsp_misaligned(rsp_misaligned),
    .rsp_illegal(rsp_illegal), .rsp_wp_hit(rsp_wp_hit), .rsp_aq(rsp_aq), .rsp_rl(rsp_rl));

  int checks = 0, fails = 0;

  // bench memory: 8 words, byte k of the space initially holds value k
  logic [63:0] mem [8];
  logic [63:0] ref_mem [8];
  logic        rd_d = 1'b0, wr_d = 1'b0;
  logic [63:0] rdat = '0;
  assign mem_rd_done = rd_d;
  assign mem_wr_done = wr_d;
  assign mem_rdata   = rdat;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mem[i] <= 64'h0706_0504_0302_0100 + 64'h0808_0808_0808_0808 * i;
      rd_d <= 1'b0;
      wr_d <= 1'b0;
    end else begin
      rd_d <= mem_rd_valid && !rd_d;
      if (mem_rd_valid && !rd_d) rdat <= mem[mem_addr[5:3]];
      wr_d <= mem_wr_valid && !wr_d;
      if (mem_wr_valid && !wr_d)
        for (int b = 0; b < 8; b++)
          if (mem_wstrb[b]) mem[mem_addr[5:3]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  typedef struct {
    logic [63:0] rd;
    logic we, mis, ill, wp, aq, rl;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) check("R11", "unexpected response", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "rd_we", 64'(rsp_rd_we), 64'(e.we));
        if (e.we) check(e.tag, "rd", rsp_rd, e.rd);
        check("R8", "misaligned", 64'(rsp_misaligned), 64'(e.mis));
        check(e.tag, "illegal", 64'(rsp_illegal), 64'(e.ill));
        check("R10", "wp_hit", 64'(rsp_wp_hit), 64'(e.wp));
        check("R11", "aq/rl", 64'({rsp_aq, rsp_rl}), 64'({e.aq, e.rl}));
      end
    end
  end

  // driver with reference model
  task automatic issue(input string tag, input logic [3:0] op, input logic [2:0] w,
                       input logic [31:0] a, input logic [63:0] rs2, input logic [63:0] cmp,
                       input logic aq = 1'b0, input logic rl = 1'b0);
    exp_t e;
    int n, sh, off, idx;
    logic [63:0] msk, oldv, so, sb2, rb, cb, nv;
    logic wr;
    n = (w == 3'd0) ? 1 : (w == 3'd1) ? 2 : (w == 3'd2) ? 4 : 8;
    e.tag = tag; e.aq = aq; e.rl = rl; e.rd = '0; e.wp = 1'b0;
    e.ill = (w > 3'd3) || (op > 4'd9);
    e.mis = !e.ill && ((a % n) != 0);
    e.we  = !e.ill && !e.mis;
    if (e.we) begin
      idx = int'(a[5:3]); off = int'(a[2:0]);
      sh  = 64 - 8 * n;
      msk = (n == 8) ? '1 : ((64'd1 << (8 * n)) - 64'd1);
      oldv = '0;
      for (int i = 0; i < n; i++) oldv[8*i +: 8] = ref_mem[idx][8*(off+i) +: 8];
      rb  = rs2 & msk;
      cb  = cmp & msk;
      so  = $signed(oldv << sh) >>> sh;
      sb2 = $signed(rb << sh) >>> sh;
      wr  = 1'b1;
      case (op)
        4'd0: nv = rb;
        4'd1: nv = (oldv + rb) & msk;
        4'd2: nv = oldv ^ rb;
        4'd3: nv = oldv & rb;
        4'd4: nv = oldv | rb;
        4'd5: nv = ($signed(so) <= $signed(sb2)) ? oldv : rb;
        4'd6: nv = ($signed(so) >= $signed(sb2)) ? oldv : rb;
        4'd7: nv = (oldv <= rb) ? oldv : rb;
        4'd8: nv = (oldv >= rb) ? oldv : rb;
        default: begin nv = rb; wr = (oldv == cb); end
      endcase
      if (wr) for (int i = 0; i < n; i++) ref_mem[idx][8*(off+i) +: 8] = nv[8*i +: 8];
      e.rd = so;
      e.wp = wp_en && (wp_addr[31:3] == a[31:3]) &&
             (int'(wp_addr[2:0]) >= off) && (int'(wp_addr[2:0]) < off + n);
    end
    sb.push_back(e);
    @(negedge clk);
    req_op = op; req_width = w; req_addr = a; req_rs2 = rs2; req_cmp = cmp;
    req_aq = aq; req_rl = rl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    do @(negedge clk); while (!req_ready);
    for (int i = 0; i < 8; i++) check("R6", "memory word", mem[i], ref_mem[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_mem[i] = 64'h0706_0504_0302_0100 + 64'h0808_0808_0808_0808 * i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "reset ready", 64'(req_ready), 64'd1);
    check("R11", "reset idle port", 64'({rsp_valid, mem_rd_valid, mem_wr_valid}), 64'd0);

    // byte lanes, upper rs2 garbage
    issue("R4", 4'd0, 3'd0, 32'd3,  64'hDEAD_BEEF_0000_0080, '0);
    issue("R3", 4'd1, 3'd0, 32'd3,  64'hFFFF_FF00_0000_0001, '0);
    issue("R7", 4'd8, 3'd0, 32'd3,  64'h1234_5678_9ABC_DE7F, '0);
    issue("R7", 4'd6, 3'd0, 32'd3,  64'hFFFF_FFFF_FFFF_FF7F, '0);
    issue("R7", 4'd7, 3'd0, 32'd6,  64'h0000_0000_0000_00F0, '0);
    issue("R2", 4'd2, 3'd0, 32'd9,  64'hAAAA_AAAA_AAAA_AA3C, '0);
    issue("R2", 4'd3, 3'd0, 32'd15, 64'h0000_0000_0000_0F0F, '0);
    issue("R2", 4'd4, 3'd0, 32'd16, 64'hFFFF_FFFF_FFFF_FF80, '0);
    // halfword lanes
    issue("R7", 4'd5, 3'd1, 32'd10, 64'h0000_0000_0000_8000, '0);
    issue("R7", 4'd7, 3'd1, 32'd12, 64'hFFFF_0000_0000_FFFF, '0, 1'b1, 1'b0);
    issue("R2", 4'd1, 3'd1, 32'd46, 64'h7777_7777_7777_FFFF, '0, 1'b0, 1'b1);
    // word and doubleword
    issue("R1", 4'd2, 3'd2, 32'd20, 64'hFFFF_FFFF_8000_0001, '0);
    issue("R1", 4'd1, 3'd3, 32'd24, 64'h0000_0001_0000_0001, '0, 1'b1, 1'b1);
    // compare-and-swap, upper expected bits garbage
    issue("R5", 4'd0, 3'd0, 32'd5,  64'h0000_0000_0000_005A, '0);
    issue("R5", 4'd9, 3'd0, 32'd5,  64'h0000_0000_0000_00A5, 64'hFFFF_FFFF_FFFF_FF5A);
    issue("R5", 4'd9, 3'd0, 32'd5,  64'h0000_0000_0000_0011, 64'h0000_0000_0000_005A);
    issue("R5", 4'd9, 3'd1, 32'd50, 64'h0000_0000_0000_BEEF, 64'h1111_2222_3333_3332);
    // faults and illegal encodings
    issue("R8", 4'd1, 3'd1, 32'd7,  64'd1, '0);
    issue("R8", 4'd1, 3'd2, 32'd34, 64'd1, '0);
    issue("R1", 4'd1, 3'd4, 32'd8,  64'd1, '0);
    issue("R9", 4'd10, 3'd0, 32'd8, 64'd1, '0);
    issue("R9", 4'd11, 3'd1, 32'd8, 64'd1, '0);
    // watchpoint on byte 41
    wp_en = 1'b1; wp_addr = 32'd41;
    issue("R10", 4'd0, 3'd0, 32'd40, 64'h0000_0000_0000_0099, '0);
    issue("R10", 4'd0, 3'd1, 32'd40, 64'h0000_0000_0000_1234, '0);
    issue("R10", 4'd0, 3'd1, 32'd41, 64'h0000_0000_0000_5678, '0);
    issue("R10", 4'd0, 3'd0, 32'd42, 64'h0000_0000_0000_0001, '0);
    wp_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "scoreboard drained", 64'(sb.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule